// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers twenty interrupt source lines and sends each one to a normal request output, a fast request output, or both, according to two enable masks. Each source carries a three-bit priority, where 0 is the most urgent. Among the sources that are allowed to fire, a priority search picks a winner. Software reads a vector word that joins a programmable base field with the winner's index, so the handler address comes out of a single load.

Four sources come from external pins rather than from on-chip logic. Each pin first passes through a two-flop synchroniser. Each pin can then act as a level input, or as a rising-edge or falling-edge input whose request stays latched until software clears it. Optional nesting keeps a per-level in-service mask for each request class. Reading a vector marks the winner's level as in service, and from then on only strictly more urgent sources raise the request. Writing the matching mask bit releases that level again.

Registers are reached over a word-addressed bus with single-cycle write and read strobes. Read data is combinational and valid in the cycle of the strobe. Writes take effect at the clock edge that ends the strobe. The bus has no back-pressure: every strobe is accepted in its own cycle.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The normal status (address 3) reads raw (address 0) ANDed with the normal enable (address 1). The fast status (address 4) reads raw ANDed with the fast enable (address 2). With nesting off, `irq_o` is high exactly when the normal status is nonzero and `fiq_o` is low.
- R2: Both vector words (normal at address 6, fast at address 7) read bits 31:23 as 0, bits 22:7 as the 16-bit base (address 5), bits 6:2 as the winning source index, and bits 1:0 as 0. The index field reads 0 when no source is eligible.
- R3: While `fiq_o` is high, `irq_o` is held low, even when a normal source is pending.
- R4: The priority of source i sits at address 8 + i/8, bits 4*(i%8)+2 down to 4*(i%8). The smallest priority value wins. Between equal priorities, the lower source index wins.
- R5: Normal nesting is enabled by bit 0 of address 11. In that mode, reading the normal vector while a normal source is eligible sets bit p of the normal in-service mask (address 12), where p is the winner's priority. A source is eligible only if its priority is strictly below the lowest set bit of that mask.
- R6: Fast nesting is enabled by bit 1 of address 11. It behaves as R5 does, using the fast vector and the fast in-service mask at address 13.
- R7: Writing 1 to a bit of an in-service mask clears that bit. Writing 0 leaves the bit unchanged. A cleared level can be taken again.
- R8: With a class's nesting bit at 0, reading its vector leaves its in-service mask unchanged, and the mask has no effect on eligibility.
- R9: External pins 0 to 3 feed source indices 13, 14, 18 and 19. On those indices the `src_i` bit is ignored. Pin k's trigger mode is at address 14, bits 2k+1:2k: 01 selects rising edge and 10 selects falling edge. An edge-mode request stays set after the pin returns, until 1 is written to the source's bit of the clear register (address 15).
- R10: Trigger modes 00 and 11 make the source follow the synchronised pin level. The clear register has no effect on a source in level mode.
- R11: After reset, every register reads 0 and both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 20 | On-chip source lines, synchronous to clk |
| ext_i | input | 4 | External pins, asynchronous |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (vector reads have side effects) |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions assume that the bus never raises the read and write strobes in the same cycle, and that `src_i` is already synchronous to the clock. They also assume that an external pin holds each level long enough to cross the synchroniser, which takes at least three cycles. The stimulus issues one strobe at a time, with an idle cycle between accesses. It holds every external pin level for six cycles before it looks at the result.

// File: rtl/vic_pkg.sv
package vic_pkg;

  typedef enum logic [3:0] {
    A_RAW      = 4'd0,
    A_IRQ_EN   = 4'd1,
    A_FIQ_EN   = 4'd2,
    A_IRQ_STAT = 4'd3,
    A_FIQ_STAT = 4'd4,
    A_BASE     = 4'd5,
    A_IRQ_VEC  = 4'd6,
    A_FIQ_VEC  = 4'd7,
    A_PRIO0    = 4'd8,
    A_PRIO1    = 4'd9,
    A_PRIO2    = 4'd10,
    A_NEST_CTL = 4'd11,
    A_IRQ_NEST = 4'd12,
    A_FIQ_NEST = 4'd13,
    A_EXT_MODE = 4'd14,
    A_EXT_CLR  = 4'd15
  } reg_addr_e;

  typedef enum logic [1:0] {
    TRIG_LEVEL  = 2'b00,
    TRIG_RISE   = 2'b01,
    TRIG_FALL   = 2'b10,
    TRIG_LEVEL2 = 2'b11
  } trig_e;

  // Source slot taken by external pin k; also its clear-bit position.
  function automatic int ext_slot(input int k);
    case (k)
      0:       return 13;
      1:       return 14;
      2:       return 18;
      default: return 19;
    endcase
  endfunction

endpackage

// File: rtl/vic_ext_in.sv
module vic_ext_in
  import vic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] mode_i,
  input  logic       clr_i,
  output logic       req_o
);
  logic s1_q, s2_q, prev_q, latch_q;
  logic edge_mode, hit;

  assign edge_mode = (mode_i == TRIG_RISE) || (mode_i == TRIG_FALL);
  assign hit = ((mode_i == TRIG_RISE) && s2_q && !prev_q) ||
               ((mode_i == TRIG_FALL) && !s2_q && prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      s1_q    <= pin_i;
      s2_q    <= s1_q;
      prev_q  <= s2_q;
      latch_q <= (latch_q && !clr_i) || hit;
    end
  end

  assign req_o = edge_mode ? latch_q : s2_q;

  AST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !clr_i) |=> latch_q); // R9

endmodule

// File: rtl/vic_arb.sv
module vic_arb #(
  parameter int NUM_SRC = 20,
  parameter int PRIO_W  = 3,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int LEVELS = 1 << PRIO_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        active_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic                      nest_en_i,
  input  logic [LEVELS-1:0]         in_svc_i,
  output logic                      req_o,
  output logic [IDX_W-1:0]          win_o,
  output logic [PRIO_W-1:0]         win_prio_o
);
  logic [PRIO_W:0]      thr;
  logic [NUM_SRC-1:0]   elig;

  always_comb begin
    thr = PRIO_W'(0) + (PRIO_W+1)'(LEVELS);
    if (nest_en_i) begin
      for (int j = LEVELS - 1; j >= 0; j--) begin
        if (in_svc_i[j]) thr = (PRIO_W+1)'(j);
      end
    end
    for (int i = 0; i < NUM_SRC; i++) begin
      elig[i] = active_i[i] && ({1'b0, prio_i[i*PRIO_W +: PRIO_W]} < thr);
    end
  end

  always_comb begin
    req_o      = 1'b0;
    win_o      = '0;
    win_prio_o = '1;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i] && (!req_o || prio_i[i*PRIO_W +: PRIO_W] <= win_prio_o)) begin
        req_o      = 1'b1;
        win_o      = IDX_W'(i);
        win_prio_o = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
    if (!req_o) win_prio_o = '0;
  end

  AST_WIN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> active_i[win_o]); // R4

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 20,
  parameter int PRIO_W  = 3,
  parameter int BASE_W  = 16,
  parameter int NUM_EXT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_EXT-1:0] ext_i,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [3:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int IDX_W     = $clog2(NUM_SRC);
  localparam int LEVELS    = 1 << PRIO_W;
  localparam int PER_WORD  = 8;
  localparam int PRIO_REGS = (NUM_SRC + PER_WORD - 1) / PER_WORD;
  localparam int IDX_LSB   = 2;
  localparam int BASE_LSB  = IDX_LSB + IDX_W;

  logic [NUM_SRC-1:0]        irq_en_q, fiq_en_q, raw, irq_stat, fiq_stat;
  logic [BASE_W-1:0]         base_q;
  logic [NUM_SRC*PRIO_W-1:0] prio_q;
  logic [1:0]                nest_ctl_q;
  logic [LEVELS-1:0]         irq_nest_q, fiq_nest_q;
  logic [2*NUM_EXT-1:0]      ext_mode_q;
  logic [NUM_EXT-1:0]        ext_req, ext_clr;
  logic                      irq_any, fiq_any;
  logic [IDX_W-1:0]          irq_win, fiq_win;
  logic [PRIO_W-1:0]         irq_wprio, fiq_wprio;
  logic [31:0]               irq_vec, fiq_vec;
  logic                      rd_irq_vec, rd_fiq_vec;

  for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
    assign ext_clr[k] = bus_wr && (bus_addr == A_EXT_CLR) && bus_wdata[ext_slot(k)];
    vic_ext_in u_ext (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (ext_i[k]),
      .mode_i(ext_mode_q[2*k +: 2]),
      .clr_i (ext_clr[k]),
      .req_o (ext_req[k])
    );
  end

  always_comb begin
    raw = src_i;
    for (int k = 0; k < NUM_EXT; k++) raw[ext_slot(k)] = ext_req[k];
  end

  assign irq_stat = raw & irq_en_q;
  assign fiq_stat = raw & fiq_en_q;

  vic_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb_irq (
    .clk(clk), .rst_n(rst_n), .active_i(irq_stat), .prio_i(prio_q),
    .nest_en_i(nest_ctl_q[0]), .in_svc_i(irq_nest_q),
    .req_o(irq_any), .win_o(irq_win), .win_prio_o(irq_wprio)
  );

  vic_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb_fiq (
    .clk(clk), .rst_n(rst_n), .active_i(fiq_stat), .prio_i(prio_q),
    .nest_en_i(nest_ctl_q[1]), .in_svc_i(fiq_nest_q),
    .req_o(fiq_any), .win_o(fiq_win), .win_prio_o(fiq_wprio)
  );

  assign fiq_o = fiq_any;
  assign irq_o = irq_any && !fiq_any;

  assign irq_vec = (32'(base_q) << BASE_LSB) | (32'(irq_win) << IDX_LSB);
  assign fiq_vec = (32'(base_q) << BASE_LSB) | (32'(fiq_win) << IDX_LSB);
  assign rd_irq_vec = bus_rd && (bus_addr == A_IRQ_VEC);
  assign rd_fiq_vec = bus_rd && (bus_addr == A_FIQ_VEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q   <= '0;
      fiq_en_q   <= '0;
      base_q     <= '0;
      prio_q     <= '0;
      nest_ctl_q <= '0;
      irq_nest_q <= '0;
      fiq_nest_q <= '0;
      ext_mode_q <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_IRQ_EN:   irq_en_q   <= bus_wdata[NUM_SRC-1:0];
          A_FIQ_EN:   fiq_en_q   <= bus_wdata[NUM_SRC-1:0];
          A_BASE:     base_q     <= bus_wdata[BASE_W-1:0];
          A_NEST_CTL: nest_ctl_q <= bus_wdata[1:0];
          A_EXT_MODE: ext_mode_q <= bus_wdata[2*NUM_EXT-1:0];
          default: ;
        endcase
        for (int w = 0; w < PRIO_REGS; w++) begin
          for (int s = 0; s < PER_WORD; s++) begin
            if ((bus_addr == 4'(A_PRIO0 + w)) && (w*PER_WORD + s < NUM_SRC))
              prio_q[(w*PER_WORD + s)*PRIO_W +: PRIO_W] <= bus_wdata[4*s +: PRIO_W];
          end
        end
      end
      if (bus_wr && bus_addr == A_IRQ_NEST)
        irq_nest_q <= irq_nest_q & ~bus_wdata[LEVELS-1:0];
      else if (rd_irq_vec && nest_ctl_q[0] && irq_any)
        irq_nest_q <= irq_nest_q | (LEVELS'(1) << irq_wprio);
      if (bus_wr && bus_addr == A_FIQ_NEST)
        fiq_nest_q <= fiq_nest_q & ~bus_wdata[LEVELS-1:0];
      else if (rd_fiq_vec && nest_ctl_q[1] && fiq_any)
        fiq_nest_q <= fiq_nest_q | (LEVELS'(1) << fiq_wprio);
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_RAW:      bus_rdata = 32'(raw);
      A_IRQ_EN:   bus_rdata = 32'(irq_en_q);
      A_FIQ_EN:   bus_rdata = 32'(fiq_en_q);
      A_IRQ_STAT: bus_rdata = 32'(irq_stat);
      A_FIQ_STAT: bus_rdata = 32'(fiq_stat);
      A_BASE:     bus_rdata = 32'(base_q);
      A_IRQ_VEC:  bus_rdata = irq_vec;
      A_FIQ_VEC:  bus_rdata = fiq_vec;
      A_NEST_CTL: bus_rdata = 32'(nest_ctl_q);
      A_IRQ_NEST: bus_rdata = 32'(irq_nest_q);
      A_FIQ_NEST: bus_rdata = 32'(fiq_nest_q);
      A_EXT_MODE: bus_rdata = 32'(ext_mode_q);
      default: begin
        for (int w = 0; w < PRIO_REGS; w++) begin
          for (int s = 0; s < PER_WORD; s++) begin
            if ((bus_addr == 4'(A_PRIO0 + w)) && (w*PER_WORD + s < NUM_SRC))
              bus_rdata[4*s +: PRIO_W] = prio_q[(w*PER_WORD + s)*PRIO_W +: PRIO_W];
          end
        end
      end
    endcase
  end

  AST_VEC_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_irq_vec || rd_fiq_vec) |->
      (bus_rdata[1:0] == 2'b00 && bus_rdata[31:BASE_LSB+BASE_W] == '0)); // R2

  AST_REQ_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_stat != '0)); // R1

  AST_FIQ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_stat != '0 && !nest_ctl_q[1]) |-> !irq_o); // R3

  AST_NEST_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_irq_vec && !bus_wr && nest_ctl_q[0] && irq_any) |=>
      irq_nest_q[$past(irq_wprio)]); // R5

  AST_NEST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_irq_vec && !bus_wr && !nest_ctl_q[0]) |=> $stable(irq_nest_q)); // R8

endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] RAW = 0, IEN = 1, FEN = 2, ISTAT = 3, FSTAT = 4, BASE = 5,
                         IVEC = 6, FVEC = 7, PR0 = 8, PR1 = 9, NCTL = 11,
                         INEST = 12, FNEST = 13, XMODE = 14, XCLR = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] src_i = '0;
  logic [3:0]  ext_i = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq_o, fiq_o;
  int checks = 0, fails = 0;
  logic [31:0] d;
  logic [15:0] base_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .ext_i(ext_i),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  function automatic logic [31:0] vec(input logic [15:0] b, input int idx);
    return (32'(b) << 7) | (32'(idx) << 2);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clean();
    src_i = '0; ext_i = '0;
    wr(IEN, 0); wr(FEN, 0); wr(NCTL, 0); wr(XMODE, 0);
    wr(INEST, 32'hFF); wr(FNEST, 32'hFF);
    wr(PR0, 0); wr(PR1, 0); wr(PR0 + 2, 0);
  endtask

  task automatic t_reset();
    chk("R11 irq_o", 32'(irq_o), 0);
    chk("R11 fiq_o", 32'(fiq_o), 0);
    rd(IEN, d);  chk("R11 irq enable", d, 0);
    rd(BASE, d); chk("R11 base", d, 0);
    rd(INEST, d); chk("R11 nest mask", d, 0);
  endtask

  task automatic t_status();
    clean();
    src_i = (20'd1 << 8) | (20'd1 << 3);
    wr(IEN, 32'd1 << 8);
    rd(RAW, d);   chk("R1 raw", d, (32'd1 << 8) | (32'd1 << 3));
    rd(ISTAT, d); chk("R1 status", d, 32'd1 << 8);
    chk("R1 irq_o high", 32'(irq_o), 1);
    rd(FSTAT, d); chk("R1 fast status empty", d, 0);
    src_i = 20'd1 << 3; idle(1);
    chk("R1 irq_o low", 32'(irq_o), 0);
  endtask

  task automatic t_vector();
    clean();
    base_v = 16'hABCD;
    wr(BASE, 32'(base_v));
    rd(IVEC, d); chk("R2 vector idle", d, vec(base_v, 0));
    src_i = 20'd1 << 8; wr(IEN, 32'd1 << 8);
    rd(IVEC, d); chk("R2 vector source 8", d, vec(base_v, 8));
  endtask

  task automatic t_priority();
    clean();
    src_i = (20'd1 << 3) | (20'd1 << 8);
    wr(IEN, (32'd1 << 3) | (32'd1 << 8));
    wr(PR0, 32'd2 << 12); wr(PR1, 32'd5);
    rd(IVEC, d); chk("R4 lower value wins", d, vec(base_v, 3));
    wr(PR0, 32'd5 << 12);
    rd(IVEC, d); chk("R4 tie lower index", d, vec(base_v, 3));
    wr(PR1, 32'd1);
    rd(IVEC, d); chk("R4 source 8 wins", d, vec(base_v, 8));
  endtask

  task automatic t_fast();
    clean();
    src_i = (20'd1 << 8) | (20'd1 << 5);
    wr(IEN, 32'd1 << 8); wr(FEN, 32'd1 << 5);
    chk("R3 fiq_o", 32'(fiq_o), 1);
    chk("R3 irq_o held", 32'(irq_o), 0);
    rd(FVEC, d); chk("R3 fast vector", d, vec(base_v, 5));
    src_i = 20'd1 << 8; idle(1);
    chk("R3 irq_o released", 32'(irq_o), 1);
  endtask

  task automatic t_nest_irq();
    clean();
    wr(PR0, 32'd4 << 12); wr(PR1, 32'd1);
    wr(IEN, (32'd1 << 3) | (32'd1 << 8));
    src_i = 20'd1 << 3;
    wr(NCTL, 1);
    rd(IVEC, d); chk("R5 vector", d, vec(base_v, 3));
    rd(INEST, d); chk("R5 level 4 marked", d, 32'h10);
    chk("R5 equal level blocked", 32'(irq_o), 0);
    src_i = (20'd1 << 3) | (20'd1 << 8); idle(1);
    chk("R5 higher preempts", 32'(irq_o), 1);
    rd(IVEC, d); chk("R5 nested vector", d, vec(base_v, 8));
    rd(INEST, d); chk("R5 two levels", d, 32'h12);
    chk("R5 all blocked", 32'(irq_o), 0);
    wr(INEST, 32'h02);
    rd(INEST, d); chk("R7 level 1 released", d, 32'h10);
    chk("R7 source 8 again", 32'(irq_o), 1);
    wr(INEST, 32'h10);
    rd(INEST, d); chk("R7 all released", d, 0);
  endtask

  task automatic t_nest_fiq();
    clean();
    wr(PR0, 32'd2 << 20);
    wr(FEN, 32'd1 << 5);
    src_i = 20'd1 << 5;
    wr(NCTL, 2);
    rd(FVEC, d); chk("R6 fast vector", d, vec(base_v, 5));
    rd(FNEST, d); chk("R6 level 2 marked", d, 32'h4);
    chk("R6 fiq_o blocked", 32'(fiq_o), 0);
    wr(FNEST, 32'h4);
    chk("R7 fiq_o again", 32'(fiq_o), 1);
  endtask

  task automatic t_nest_off();
    clean();
    wr(IEN, 32'd1 << 8); src_i = 20'd1 << 8;
    rd(IVEC, d); rd(IVEC, d);
    rd(INEST, d); chk("R8 mask untouched", d, 0);
    chk("R8 irq_o stays", 32'(irq_o), 1);
  endtask

  task automatic t_edge();
    clean();
    wr(IEN, (32'd1 << 13) | (32'd1 << 19));
    wr(XMODE, 32'h81);
    ext_i[0] = 1'b1; idle(6);
    rd(RAW, d); chk("R9 rising latched", 32'(d[13]), 1);
    ext_i[0] = 1'b0; idle(6);
    rd(RAW, d); chk("R9 held after pin drops", 32'(d[13]), 1);
    chk("R9 irq_o held", 32'(irq_o), 1);
    wr(XCLR, 32'd1 << 13);
    rd(RAW, d); chk("R9 cleared", 32'(d[13]), 0);
    chk("R9 irq_o low", 32'(irq_o), 0);
    ext_i[3] = 1'b1; idle(6);
    rd(RAW, d); chk("R9 falling ignores rise", 32'(d[19]), 0);
    ext_i[3] = 1'b0; idle(6);
    rd(RAW, d); chk("R9 falling latched", 32'(d[19]), 1);
    wr(XCLR, 32'd1 << 19);
    rd(RAW, d); chk("R9 falling cleared", 32'(d[19]), 0);
  endtask

  task automatic t_level();
    clean();
    src_i = 20'd1 << 18; idle(4);
    rd(RAW, d); chk("R9 src bit on pin slot ignored", 32'(d[18]), 0);
    ext_i[1] = 1'b1; idle(6);
    rd(RAW, d); chk("R10 level high", 32'(d[14]), 1);
    wr(XCLR, 32'd1 << 14);
    rd(RAW, d); chk("R10 clear no effect", 32'(d[14]), 1);
    ext_i[1] = 1'b0; idle(6);
    rd(RAW, d); chk("R10 level low", 32'(d[14]), 0);
  endtask

  initial begin
    base_v = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_status();
    t_vector();
    t_priority();
    t_fast();
    t_nest_irq();
    t_nest_fiq();
    t_nest_off();
    t_edge();
    t_level();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule